// File: doc/BRIEF.md
# Receive DMA Channel with Byte Packer

This block carries a byte stream from a receiving peripheral into memory. Each accepted byte is placed in the lane of a 32-bit word that matches the low bits of its destination address. The gathered word is written through a simple write port with byte enables. The port holds each request until it is acknowledged.

Two buffer descriptors, each a base address, a byte limit and a ready flag, are used in turn. A buffer ends in one of two ways: the peripheral marks its last byte, or the number of bytes that entered the packer reaches the limit. When a buffer ends, the partly filled word is flushed, an interrupt pulse is raised, and a status field names the descriptor now in use. If that descriptor is not ready, the channel halts and flags an underrun.

Top module: `rx_dma_packer`

## Requirements
- R1: A byte written to byte address A goes to lane A mod 4, in bits 8*(A mod 4)+7 down to 8*(A mod 4), of a write to the word address A with its two low bits cleared. Lanes that hold no byte have their enable bit low, and every write has at least one enable bit high.
- R2: A write is issued as soon as a byte lands in lane 3. Once lane 3 is filled, no later byte shares that word.
- R3: When a buffer base is not word aligned, the first write of that buffer enables only the lanes from the base lane up to lane 3.
- R4: A byte with the end flag set flushes every byte held in the packer, whatever lanes are filled, and the channel moves to the other descriptor.
- R5: A byte that carries both end and error, while the ignore-error input is low, is not written and does not count. Only the bytes before it are flushed. If the packer holds nothing, no write occurs, but the buffer still terminates.
- R6: A byte that carries both end and error, while the ignore-error input is high, is written like any other byte.
- R7: When the bytes that entered the packer for the current buffer reach that buffer's limit, the buffer terminates as if end had arrived. tc pulses for exactly one cycle, together with irq.
- R8: Each termination gives exactly one one-cycle irq pulse. In the same cycle, next_sel changes to the index of the descriptor now in use (0 after reset).
- R9: While a write is pending and not acknowledged, in_ready is low and the write address, enables and data are held.
- R10: If the descriptor to switch to has its ready flag low when a buffer terminates, underrun goes high and stays high until reset. in_ready stays low from then on, even if the flag later rises.
- R11: During reset, mem_we, irq, tc, underrun, next_sel and in_ready are all low. One cycle after reset, with descriptor 0 ready, in_ready is high.
- R12: A new buffer starts at its own base address. No write combines bytes of two buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte offered by the peripheral |
| in_data | input | 8 | Byte value |
| in_end | input | 1 | Byte is the last of the buffer's data |
| in_err | input | 1 | Last byte is erroneous (with in_end) |
| in_ready | output | 1 | Channel accepts a byte this cycle |
| ign_err | input | 1 | Keep erroneous last bytes |
| base0 | input | AW | Base byte address of descriptor 0 |
| lim0 | input | CW | Byte limit of descriptor 0 |
| ok0 | input | 1 | Descriptor 0 ready |
| base1 | input | AW | Base byte address of descriptor 1 |
| lim1 | input | CW | Byte limit of descriptor 1 |
| ok1 | input | 1 | Descriptor 1 ready |
| mem_we | output | 1 | Write request pending |
| mem_addr | output | AW | Word-aligned byte address of the write |
| mem_be | output | 4 | Byte enables, bit n for lane n |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Write accepted this cycle |
| next_sel | output | 1 | Index of descriptor in use |
| irq | output | 1 | Buffer terminated (one-cycle pulse) |
| tc | output | 1 | Limit reached (one-cycle pulse) |
| underrun | output | 1 | Halted for lack of a ready descriptor |

## Verification
The bench starts the second buffer at an odd base. A design that packed from lane 0, or that carried old bytes across the switch, would show wrong enables on the first word. A dropped error byte with a non-empty packer, and another with an empty one, catch designs that write the byte anyway, that skip the flush, or that issue a write with no enables. A limit of six bytes ends one buffer mid-word and checks the terminal-count pulse. The memory acknowledges slowly, and a design that kept taking bytes during a pending write would lose data or raise ready. Clearing a descriptor flag before a termination catches a channel that runs on into an unready buffer or that recovers by itself.

// File: rtl/rxdma_pkg.sv
`timescale 1ns/1ps
package rxdma_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = $clog2(LANES);
  localparam int WORD_W = 8 * LANES;
endpackage

// File: rtl/rx_desc_ctl.sv
`timescale 1ns/1ps
module rx_desc_ctl #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base0,
  input  logic [AW-1:0] base1,
  input  logic [CW-1:0] lim0,
  input  logic [CW-1:0] lim1,
  input  logic          ok0,
  input  logic          ok1,
  input  logic          acc,
  input  logic          drop,
  input  logic          last,
  output logic [AW-1:0] ptr,
  output logic          loaded,
  output logic          stopped,
  output logic          underrun,
  output logic          cur,
  output logic          term,
  output logic          irq,
  output logic          tc
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;
  logic [CW-1:0] lim_cur;
  logic          take;
  logic          hit;
  logic          ok_cur;
  logic          ok_nxt;

  always_comb begin
    take    = acc & ~drop;
    cnt_nx  = cnt + 1'b1;
    lim_cur = cur ? lim1 : lim0;
    ok_cur  = cur ? ok1 : ok0;
    ok_nxt  = cur ? ok0 : ok1;
    hit     = take && (cnt_nx == lim_cur);
    term    = acc && (last || hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur      <= 1'b0;
      loaded   <= 1'b0;
      stopped  <= 1'b0;
      underrun <= 1'b0;
      cnt      <= '0;
      ptr      <= '0;
      irq      <= 1'b0;
      tc       <= 1'b0;
    end else begin
      irq <= term;
      tc  <= hit;
      if (term) begin
        loaded <= 1'b0;
        cur    <= ~cur;
        if (!ok_nxt) begin
          stopped  <= 1'b1;
          underrun <= 1'b1;
        end
      end else if (take) begin
        cnt <= cnt_nx;
        ptr <= ptr + 1'b1;
      end else if (!loaded && !stopped && ok_cur) begin
        loaded <= 1'b1;
        cnt    <= '0;
        ptr    <= cur ? base1 : base0;
      end
    end
  end

  // R7: the limit pulse always comes with a termination pulse
  p_tc_with_irq_r7: assert property (@(posedge clk) disable iff (rst)
    tc |-> irq);
  // R8: every termination pulse coincides with a change of descriptor
  p_sel_flips_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> (cur != $past(cur)));
  // R10: underrun is sticky
  p_underrun_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);
endmodule

// File: rtl/rx_packer.sv
`timescale 1ns/1ps
module rx_packer import rxdma_pkg::*; #(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [AW-1:0]     ptr,
  input  logic [7:0]        din,
  input  logic              flush,
  input  logic              mem_ack,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [WORD_W-1:0] mem_wdata
);
  logic [WORD_W-1:0] pk_d, nd;
  logic [LANES-1:0]  pk_b, nb;
  logic [LANE_W-1:0] lane;
  logic              fire;

  always_comb begin
    lane = ptr[LANE_W-1:0];
    nd   = pk_d;
    nb   = pk_b;
    if (take) begin
      nd[lane*8 +: 8] = din;
      nb[lane]        = 1'b1;
    end
    fire = (take && (lane == LANE_W'(LANES-1))) || (flush && (|nb));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      pk_d      <= '0;
      pk_b      <= '0;
    end else begin
      if (mem_we && mem_ack) mem_we <= 1'b0;
      if (fire || flush) begin
        pk_d <= '0;
        pk_b <= '0;
      end else begin
        pk_d <= nd;
        pk_b <= nb;
      end
      if (fire) begin
        mem_we    <= 1'b1;
        mem_addr  <= {ptr[AW-1:LANE_W], {LANE_W{1'b0}}};
        mem_be    <= nb;
        mem_wdata <= nd;
      end
    end
  end

  // R9: a pending write keeps its fields until acknowledged
  p_hold_write_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !mem_ack) |=> (mem_we && $stable(mem_addr) && $stable(mem_be)
                              && $stable(mem_wdata)));
  // R1: no write goes out with every lane disabled
  p_be_nonzero_r1: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_be != '0));
endmodule

// File: rtl/rx_dma_packer.sv
`timescale 1ns/1ps
module rx_dma_packer import rxdma_pkg::*; #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_end,
  input  logic              in_err,
  output logic              in_ready,
  input  logic              ign_err,
  input  logic [AW-1:0]     base0,
  input  logic [CW-1:0]     lim0,
  input  logic              ok0,
  input  logic [AW-1:0]     base1,
  input  logic [CW-1:0]     lim1,
  input  logic              ok1,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  output logic              next_sel,
  output logic              irq,
  output logic              tc,
  output logic              underrun
);
  logic          acc, drop, take, term, loaded, stopped;
  logic [AW-1:0] ptr;

  always_comb begin
    in_ready = loaded & ~stopped & ~mem_we;
    acc      = in_valid & in_ready;
    drop     = acc & in_end & in_err & ~ign_err;
    take     = acc & ~drop;
  end

  rx_desc_ctl #(.AW(AW), .CW(CW)) ctl_i (
    .clk(clk), .rst(rst),
    .base0(base0), .base1(base1), .lim0(lim0), .lim1(lim1),
    .ok0(ok0), .ok1(ok1),
    .acc(acc), .drop(drop), .last(in_end),
    .ptr(ptr), .loaded(loaded), .stopped(stopped), .underrun(underrun),
    .cur(next_sel), .term(term), .irq(irq), .tc(tc)
  );

  rx_packer #(.AW(AW)) pk_i (
    .clk(clk), .rst(rst),
    .take(take), .ptr(ptr), .din(in_data), .flush(term),
    .mem_ack(mem_ack),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata)
  );

  // R10: a halted channel never offers ready
  p_halt_no_ready_r10: assert property (@(posedge clk) disable iff (rst)
    underrun |-> !in_ready);
  // R9: no byte is accepted while a write waits for its acknowledge
  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !mem_ack) |=> !in_ready);
endmodule

// File: tb/rx_dma_packer_tb.sv
`timescale 1ns/1ps
module rx_dma_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_end = 1'b0, in_err = 1'b0, ign_err = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic [15:0] base0 = 16'h0100, base1 = 16'h0203;
  logic [15:0] lim0 = 16'd6, lim1 = 16'd16;
  logic        ok0 = 1'b1, ok1 = 1'b1;
  logic        mem_we, mem_ack = 1'b0;
  logic [15:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        next_sel, irq, tc, underrun;

  int errors = 0, checks = 0;
  int wr_n = 0, irq_n = 0, tc_n = 0, stall_bad = 0, wcnt = 0;
  logic [51:0] wlog [0:15];

  // stimulus: {end, err, data}
  localparam logic [9:0] STIM [0:9] = '{
    10'h0A0, 10'h0A1, 10'h0A2, 10'h0A3, 10'h0A4, 10'h0A5,
    10'h0B0, 10'h0B1, 10'h0B2, 10'h3B3 };
  // expected writes: {addr, be, data}
  localparam logic [51:0] EXPW [0:3] = '{
    {16'h0100, 4'hF, 32'hA3A2A1A0},
    {16'h0104, 4'h3, 32'h0000A5A4},
    {16'h0200, 4'h8, 32'hB0000000},
    {16'h0204, 4'h3, 32'h0000B2B1} };

  rx_dma_packer dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_end(in_end), .in_err(in_err), .in_ready(in_ready), .ign_err(ign_err),
    .base0(base0), .lim0(lim0), .ok0(ok0), .base1(base1), .lim1(lim1), .ok1(ok1),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .next_sel(next_sel), .irq(irq), .tc(tc), .underrun(underrun));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [9:0] v);
    int waited;
    in_valid = 1'b1; in_end = v[9]; in_err = v[8]; in_data = v[7:0];
    waited = 0;
    while (!in_ready && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    chk(waited < 200, "R9 ready timeout", 64'(waited), 64'd200);
    @(negedge clk);
    in_valid = 1'b0; in_end = 1'b0; in_err = 1'b0;
  endtask

  task automatic wait_writes(input int n);
    for (int k = 0; k < 100 && wr_n < n; k++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // memory responder (2-cycle latency) and pulse monitor
  initial begin
    forever begin
      @(negedge clk);
      if (irq) irq_n++;
      if (tc) tc_n++;
      if (mem_we && !mem_ack && in_ready) stall_bad++;
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_we) begin
        if (wcnt == 2) begin
          if (wr_n < 16) wlog[wr_n] = {mem_addr, mem_be, mem_wdata};
          wr_n++;
          mem_ack = 1'b1;
          wcnt = 0;
        end else begin
          wcnt++;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(mem_we == 1'b0, "R11 mem_we", 64'(mem_we), 64'd0);
    chk(irq == 1'b0, "R11 irq", 64'(irq), 64'd0);
    chk(tc == 1'b0, "R11 tc", 64'(tc), 64'd0);
    chk(underrun == 1'b0, "R11 underrun", 64'(underrun), 64'd0);
    chk(next_sel == 1'b0, "R11 next_sel", 64'(next_sel), 64'd0);
    chk(in_ready == 1'b0, "R11 ready in reset", 64'(in_ready), 64'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b1, "R11 ready after reset", 64'(in_ready), 64'd1);

    // table walk: R1 R2 R3 R4 R5 R7 R12
    for (int i = 0; i < 10; i++) send(STIM[i]);
    wait_writes(4);
    chk(wr_n == 4, "R5 write count", 64'(wr_n), 64'd4);
    for (int i = 0; i < 4; i++)
      chk(wlog[i] == EXPW[i], "R1 R2 R3 R12 write", 64'(wlog[i]), 64'(EXPW[i]));
    chk(tc_n == 1, "R7 tc pulses", 64'(tc_n), 64'd1);
    chk(irq_n == 2, "R8 irq pulses", 64'(irq_n), 64'd2);
    chk(next_sel == 1'b0, "R8 next_sel", 64'(next_sel), 64'd0);
    chk(stall_bad == 0, "R9 ready during pending write", 64'(stall_bad), 64'd0);

    // R6: keep the error byte
    ign_err = 1'b1;
    send(10'h0C0);
    send(10'h3C1);
    wait_writes(5);
    chk(wlog[4] == {16'h0100, 4'h3, 32'h0000C1C0}, "R6 error byte kept",
        64'(wlog[4]), 64'({16'h0100, 4'h3, 32'h0000C1C0}));
    chk(next_sel == 1'b1, "R8 next_sel after R6", 64'(next_sel), 64'd1);

    // R5: dropped error byte with an empty packer
    ign_err = 1'b0;
    send(10'h3E0);
    repeat (6) @(negedge clk);
    chk(wr_n == 5, "R5 no write for lone error byte", 64'(wr_n), 64'd5);
    chk(irq_n == 4, "R5 buffer still ends", 64'(irq_n), 64'd4);
    chk(next_sel == 1'b0, "R8 next_sel after drop", 64'(next_sel), 64'd0);

    // R10: underrun when the other descriptor is not ready
    ok1 = 1'b0;
    send(10'h2D0);
    wait_writes(6);
    chk(wlog[5] == {16'h0100, 4'h1, 32'h000000D0}, "R4 single-byte flush",
        64'(wlog[5]), 64'({16'h0100, 4'h1, 32'h000000D0}));
    chk(underrun == 1'b1, "R10 underrun set", 64'(underrun), 64'd1);
    chk(in_ready == 1'b0, "R10 ready low", 64'(in_ready), 64'd0);
    ok1 = 1'b1;
    repeat (5) @(negedge clk);
    chk(in_ready == 1'b0, "R10 stays halted", 64'(in_ready), 64'd0);
    chk(underrun == 1'b1, "R10 underrun sticky", 64'(underrun), 64'd1);
    chk(stall_bad == 0, "R9 ready during pending write", 64'(stall_bad), 64'd0);
    finish_run();
  end
endmodule